// File: doc/BRIEF.md
# Register Specifier Redirection Unit

This unit sits in front of the register file of a small embedded core with sixteen 32-bit architected registers, each named by a 4-bit specifier. A per-specifier map table is looked up on every access. A specifier with no entry reaches the ordinary register file. A specifier with an entry is steered to one of five small storage structures, each with its own access discipline. Slots 0 and 1 are non-destructive queues, slot 2 is a destructive queue, slot 3 is a stack and slot 4 is a circular buffer. Software can therefore keep several live values, such as loop-carried values in a software-pipelined loop, behind one specifier without widening the operand fields.

One command port maps or unmaps a specifier. A map command carries the specifier, a slot index and a depth field. The active depth of the slot is the depth field plus one, from 1 to 8 entries. The command takes effect at the next clock edge. The unit has one read port and one write port. Read data is combinational from the current state. The effects of an access on pointers and counts, such as a pop or a push, occur at the clock edge that ends the cycle.

Top module: `rsr_redirect_unit`

## Requirements
- R1: A read or write whose specifier has no valid map entry accesses the 16x32 register file. All registers read zero after reset, and read data is combinational from the current register contents.
- R2: A map command (map_en_i=1, map_unmap_i=0, map_sel_i in 0..4, depth field d giving active depth d+1) redirects the specifier starting in the next cycle and empties the selected slot. Accesses in the same cycle as the command still use the previous mapping.
- R3: An access through a mapped specifier leaves the register file untouched. After an unmap, the specifier reads the value the register held before it was mapped.
- R4: An unmap command clears the specifier's entry and empties the slot it pointed to, so that a later remap finds that slot empty. Unmapping a specifier that has no entry changes nothing.
- R5: A map command whose slot index is 5, 6 or 7 is ignored, and the specifier keeps its previous routing.
- R6: Slot 3 (stack): writes push and reads pop, so values come back in the reverse order of writing.
- R7: Slot 2 (destructive queue): writes append at the tail, and a read returns the head and removes it (first in, first out).
- R8: Slots 0 and 1 (non-destructive queue): a read returns the oldest held value without removing it. A write while the queue holds its active depth of values drops the oldest value, and the head moves to the next one.
- R9: Slot 4 (circular buffer): every read advances the read pointer and every write advances the write pointer, both wrapping modulo the active depth. The slot never raises a flag, and its stored data survives a remap, which resets only the pointers.
- R10: A read of an empty stack or queue returns zero and asserts unf_o in the same cycle.
- R11: A write to a full stack or full destructive queue asserts ovf_o and discards the value, unless a read pops the same slot in the same cycle. In that case the stack's top is replaced, or the queue accepts the value.
- R12: When a slot is read and written in the same cycle, the read returns the value held before the clock edge, and both effects are applied at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_en_i | input | 1 | Map or unmap command valid |
| map_unmap_i | input | 1 | 1 = unmap, 0 = map |
| map_spec_i | input | 4 | Specifier named by the command |
| map_depth_i | input | 3 | Active depth minus one |
| map_sel_i | input | 3 | Slot index, 0 to 4 valid |
| wr_en_i | input | 1 | Write strobe |
| wr_spec_i | input | 4 | Write specifier |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe (pops or advances a mapped slot) |
| rd_spec_i | input | 4 | Read specifier |
| rd_data_o | output | 32 | Read data, combinational |
| ovf_o | output | 1 | Write to a full stack or destructive queue this cycle |
| unf_o | output | 1 | Read of an empty stack or queue this cycle |

## Verification
The assertions assume that reset is held through at least one clock edge, and that all command and access inputs are known and settled before each rising edge. They also assume that the flags are only meaningful in cycles with a strobe. The stimulus changes inputs only on falling edges and drives all strobes low outside directed steps. The random phase limits specifiers to 0..7 so that mapped traffic, remaps to a slot in use, and simultaneous read and write to the same slot occur often. A behavioural model of the table, the register file and the five slots predicts the data and both flags in every cycle.

// File: rtl/rsr_pkg.sv
`timescale 1ns/1ps
package rsr_pkg;
  // discipline of one customized slot
  typedef enum logic [1:0] {
    K_NQ   = 2'd0,  // queue, read does not consume
    K_DQ   = 2'd1,  // queue, read consumes
    K_STK  = 2'd2,  // last in first out
    K_CIRC = 2'd3   // wrapping read/write pointers
  } kind_e;

  // fixed discipline per slot index
  function automatic kind_e kind_of(input int idx);
    case (idx)
      2:       return K_DQ;
      3:       return K_STK;
      4:       return K_CIRC;
      default: return K_NQ;
    endcase
  endfunction
endpackage

// File: rtl/rsr_regfile.sv
`timescale 1ns/1ps
module rsr_regfile #(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  localparam int SPEC_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [SPEC_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SPEC_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/rsr_map_table.sv
`timescale 1ns/1ps
module rsr_map_table #(
  parameter int NREG    = 16,
  parameter int NSTRUCT = 5,
  localparam int SPEC_W = $clog2(NREG),
  localparam int SEL_W  = $clog2(NSTRUCT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_en_i,
  input  logic               cmd_unmap_i,
  input  logic [SPEC_W-1:0]  cmd_spec_i,
  input  logic [SEL_W-1:0]   cmd_sel_i,
  input  logic [SPEC_W-1:0]  rd_spec_i,
  output logic               rd_hit_o,
  output logic [SEL_W-1:0]   rd_sel_o,
  input  logic [SPEC_W-1:0]  wr_spec_i,
  output logic               wr_hit_o,
  output logic [SEL_W-1:0]   wr_sel_o,
  output logic [NSTRUCT-1:0] clr_o,
  output logic [NSTRUCT-1:0] load_o,
  output logic [NREG-1:0]    valid_o
);
  logic [NREG-1:0]  valid_q;
  logic [SEL_W-1:0] sel_q [NREG];
  logic             sel_ok;
  logic             do_map, do_unmap;

  assign sel_ok   = {1'b0, cmd_sel_i} < (SEL_W+1)'(NSTRUCT);
  assign do_map   = cmd_en_i && !cmd_unmap_i && sel_ok;
  assign do_unmap = cmd_en_i && cmd_unmap_i && valid_q[cmd_spec_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < NREG; i++) sel_q[i] <= '0;
    end else if (do_map) begin
      valid_q[cmd_spec_i] <= 1'b1;
      sel_q[cmd_spec_i]   <= cmd_sel_i;
    end else if (do_unmap) begin
      valid_q[cmd_spec_i] <= 1'b0;
    end
  end

  for (genvar s = 0; s < NSTRUCT; s++) begin : g_slot_ctl
    assign load_o[s] = do_map && (cmd_sel_i == SEL_W'(s));
    assign clr_o[s]  = load_o[s] || (do_unmap && (sel_q[cmd_spec_i] == SEL_W'(s)));
  end

  assign rd_hit_o = valid_q[rd_spec_i];
  assign rd_sel_o = sel_q[rd_spec_i];
  assign wr_hit_o = valid_q[wr_spec_i];
  assign wr_sel_o = sel_q[wr_spec_i];
  assign valid_o  = valid_q;
endmodule

// File: rtl/rsr_slot.sv
`timescale 1ns/1ps
module rsr_slot #(
  parameter rsr_pkg::kind_e KIND = rsr_pkg::K_NQ,
  parameter int DATA_W    = 32,
  parameter int MAX_DEPTH = 8,
  localparam int PW = $clog2(MAX_DEPTH),
  localparam int CW = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [CW-1:0]     depth_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic [DATA_W-1:0] mem_q [MAX_DEPTH];
  logic [PW-1:0]     rp_q, wp_q, rp_n, wp_n, waddr;
  logic [CW-1:0]     cnt_q, cnt_n, dep_q;
  logic              we;
  logic              empty, full;

  // pointer step that wraps at the active depth
  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p,
                                             input logic [CW-1:0] d);
    logic [CW-1:0] n;
    n = CW'(p) + CW'(1);
    return (n >= d) ? '0 : PW'(n);
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == dep_q);

  if (KIND == rsr_pkg::K_NQ) begin : g_nq
    always_comb begin
      rdata_o = empty ? '0 : mem_q[rp_q];
      unf_o   = rd_i && empty;
      ovf_o   = 1'b0;
      we      = wr_i;
      waddr   = wp_q;
      wp_n    = wr_i ? wrap_inc(wp_q, dep_q) : wp_q;
      rp_n    = (wr_i && full) ? wrap_inc(rp_q, dep_q) : rp_q;
      cnt_n   = (wr_i && !full) ? cnt_q + CW'(1) : cnt_q;
    end
  end else if (KIND == rsr_pkg::K_DQ) begin : g_dq
    logic pop, push;
    always_comb begin
      pop     = rd_i && !empty;
      push    = wr_i && (!full || pop);
      rdata_o = empty ? '0 : mem_q[rp_q];
      unf_o   = rd_i && empty;
      ovf_o   = wr_i && !push;
      we      = push;
      waddr   = wp_q;
      wp_n    = push ? wrap_inc(wp_q, dep_q) : wp_q;
      rp_n    = pop ? wrap_inc(rp_q, dep_q) : rp_q;
      case ({push, pop})
        2'b10:   cnt_n = cnt_q + CW'(1);
        2'b01:   cnt_n = cnt_q - CW'(1);
        default: cnt_n = cnt_q;
      endcase
    end
  end else if (KIND == rsr_pkg::K_STK) begin : g_stk
    logic          pop;
    logic [PW-1:0] top;
    always_comb begin
      top     = PW'(cnt_q - CW'(1));
      pop     = rd_i && !empty;
      rdata_o = empty ? '0 : mem_q[top];
      unf_o   = rd_i && empty;
      ovf_o   = wr_i && full && !pop;
      rp_n    = rp_q;
      wp_n    = wp_q;
      we      = 1'b0;
      waddr   = top;
      cnt_n   = cnt_q;
      if (wr_i && pop) begin
        we = 1'b1;
      end else if (wr_i && !full) begin
        we    = 1'b1;
        waddr = PW'(cnt_q);
        cnt_n = cnt_q + CW'(1);
      end else if (pop) begin
        cnt_n = cnt_q - CW'(1);
      end
    end
  end else begin : g_circ
    always_comb begin
      rdata_o = mem_q[rp_q];
      unf_o   = 1'b0;
      ovf_o   = 1'b0;
      we      = wr_i;
      waddr   = wp_q;
      wp_n    = wr_i ? wrap_inc(wp_q, dep_q) : wp_q;
      rp_n    = rd_i ? wrap_inc(rp_q, dep_q) : rp_q;
      cnt_n   = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_DEPTH; i++) mem_q[i] <= '0;
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
      dep_q <= CW'(MAX_DEPTH);
    end else begin
      if (we) mem_q[waddr] <= wdata_i;
      if (clr_i) begin
        rp_q  <= '0;
        wp_q  <= '0;
        cnt_q <= '0;
      end else begin
        rp_q  <= rp_n;
        wp_q  <= wp_n;
        cnt_q <= cnt_n;
      end
      if (load_i) dep_q <= depth_i;
    end
  end
endmodule

// File: rtl/rsr_redirect_unit.sv
`timescale 1ns/1ps
module rsr_redirect_unit #(
  parameter int NREG      = 16,
  parameter int DATA_W    = 32,
  parameter int NSTRUCT   = 5,
  parameter int MAX_DEPTH = 8,
  localparam int SPEC_W = $clog2(NREG),
  localparam int SEL_W  = $clog2(NSTRUCT),
  localparam int DF_W   = $clog2(MAX_DEPTH),
  localparam int CW     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_en_i,
  input  logic              map_unmap_i,
  input  logic [SPEC_W-1:0] map_spec_i,
  input  logic [DF_W-1:0]   map_depth_i,
  input  logic [SEL_W-1:0]  map_sel_i,
  input  logic              wr_en_i,
  input  logic [SPEC_W-1:0] wr_spec_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [SPEC_W-1:0] rd_spec_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ovf_o,
  output logic              unf_o
);
  // named internal events, observed by the checker
  logic               rd_hit, wr_hit;
  logic [SEL_W-1:0]   rd_sel, wr_sel;
  logic [NSTRUCT-1:0] slot_clr, slot_load;
  logic [NSTRUCT-1:0] rd_fire, wr_fire;
  logic [NSTRUCT-1:0] slot_ovf, slot_unf;
  logic [NREG-1:0]    tbl_valid;
  logic [DATA_W-1:0]  slot_rdata [NSTRUCT];
  logic [DATA_W-1:0]  rf_rdata;
  logic [CW-1:0]      active_depth;

  assign active_depth = CW'(map_depth_i) + CW'(1);

  rsr_map_table #(.NREG(NREG), .NSTRUCT(NSTRUCT)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_en_i   (map_en_i),
    .cmd_unmap_i(map_unmap_i),
    .cmd_spec_i (map_spec_i),
    .cmd_sel_i  (map_sel_i),
    .rd_spec_i  (rd_spec_i),
    .rd_hit_o   (rd_hit),
    .rd_sel_o   (rd_sel),
    .wr_spec_i  (wr_spec_i),
    .wr_hit_o   (wr_hit),
    .wr_sel_o   (wr_sel),
    .clr_o      (slot_clr),
    .load_o     (slot_load),
    .valid_o    (tbl_valid)
  );

  rsr_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (wr_en_i && !wr_hit),
    .waddr_i(wr_spec_i),
    .wdata_i(wr_data_i),
    .raddr_i(rd_spec_i),
    .rdata_o(rf_rdata)
  );

  for (genvar s = 0; s < NSTRUCT; s++) begin : g_slot
    localparam rsr_pkg::kind_e K = rsr_pkg::kind_of(s);
    assign rd_fire[s] = rd_en_i && rd_hit && (rd_sel == SEL_W'(s));
    assign wr_fire[s] = wr_en_i && wr_hit && (wr_sel == SEL_W'(s));
    rsr_slot #(.KIND(K), .DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (slot_clr[s]),
      .load_i (slot_load[s]),
      .depth_i(active_depth),
      .rd_i   (rd_fire[s]),
      .wr_i   (wr_fire[s]),
      .wdata_i(wr_data_i),
      .rdata_o(slot_rdata[s]),
      .ovf_o  (slot_ovf[s]),
      .unf_o  (slot_unf[s])
    );
  end

  assign rd_data_o = rd_hit ? slot_rdata[rd_sel] : rf_rdata;
  assign ovf_o     = |slot_ovf;
  assign unf_o     = |slot_unf;
endmodule

// File: rtl/rsr_redirect_chk.sv
`timescale 1ns/1ps
module rsr_redirect_chk #(
  parameter int NREG    = 16,
  parameter int DATA_W  = 32,
  parameter int NSTRUCT = 5,
  localparam int SPEC_W = $clog2(NREG),
  localparam int SEL_W  = $clog2(NSTRUCT)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               map_en_i,
  input logic               map_unmap_i,
  input logic [SPEC_W-1:0]  map_spec_i,
  input logic [SEL_W-1:0]   map_sel_i,
  input logic               rd_en_i,
  input logic               wr_en_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               ovf_o,
  input logic               unf_o,
  input logic               rd_hit,
  input logic               wr_hit,
  input logic [NSTRUCT-1:0] rd_fire,
  input logic [NREG-1:0]    tbl_valid
);
  // R3
  rd_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_fire));

  // R10
  unf_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> (rd_data_o == '0));

  // R10
  unf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> (rd_en_i && rd_hit));

  // R11
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (wr_en_i && wr_hit));

  // R2
  map_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_en_i && !map_unmap_i && ({1'b0, map_sel_i} < (SEL_W+1)'(NSTRUCT)))
    |=> tbl_valid[$past(map_spec_i)]);

  // R4
  unmap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_en_i && map_unmap_i) |=> !tbl_valid[$past(map_spec_i)]);

  // R5
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_en_i && !map_unmap_i && ({1'b0, map_sel_i} >= (SEL_W+1)'(NSTRUCT)))
    |=> $stable(tbl_valid));
endmodule

bind rsr_redirect_unit rsr_redirect_chk #(
  .NREG(NREG), .DATA_W(DATA_W), .NSTRUCT(NSTRUCT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .map_en_i   (map_en_i),
  .map_unmap_i(map_unmap_i),
  .map_spec_i (map_spec_i),
  .map_sel_i  (map_sel_i),
  .rd_en_i    (rd_en_i),
  .wr_en_i    (wr_en_i),
  .rd_data_o  (rd_data_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o),
  .rd_hit     (rd_hit),
  .wr_hit     (wr_hit),
  .rd_fire    (rd_fire),
  .tbl_valid  (tbl_valid)
);

// File: tb/rsr_redirect_unit_bench.sv
`timescale 1ns/1ps
module rsr_redirect_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_en = 0, map_unmap = 0;
  logic [3:0]  map_spec = 0;
  logic [2:0]  map_depth = 0, map_sel = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [3:0]  wr_spec = 0, rd_spec = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        ovf, unf;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rsr_redirect_unit u_rsr_redirect_unit (
    .clk(clk), .rst_n(rst_n),
    .map_en_i(map_en), .map_unmap_i(map_unmap), .map_spec_i(map_spec),
    .map_depth_i(map_depth), .map_sel_i(map_sel),
    .wr_en_i(wr_en), .wr_spec_i(wr_spec), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_spec_i(rd_spec),
    .rd_data_o(rd_data), .ovf_o(ovf), .unf_o(unf)
  );

  // behavioural model
  logic [31:0] m_rf [16];
  bit          m_mapped [16];
  int          m_slot [16];
  logic [31:0] m_mem [5][8];
  int          m_cnt [5], m_rp [5], m_wp [5], m_dep [5];

  // 0,1: keeping queue  2: consuming queue  3: stack  4: circular
  function automatic int kind(input int s);
    return (s < 2) ? 0 : s - 1;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_rf[i] = 0; m_mapped[i] = 0; m_slot[i] = 0;
    end
    for (int s = 0; s < 5; s++) begin
      for (int j = 0; j < 8; j++) m_mem[s][j] = 0;
      m_cnt[s] = 0; m_rp[s] = 0; m_wp[s] = 0; m_dep[s] = 8;
    end
  endtask

  task automatic step(input string tag,
                      input bit me, input bit mu, input int msp, input int mdf, input int msl,
                      input bit we, input int wsp, input logic [31:0] wd,
                      input bit re, input int rsp);
    logic [31:0] exp_d;
    bit exp_unf, exp_ovf, pop_same;
    int rs, ws;
    @(negedge clk);
    map_en = me; map_unmap = mu; map_spec = 4'(msp); map_depth = 3'(mdf); map_sel = 3'(msl);
    wr_en = we; wr_spec = 4'(wsp); wr_data = wd;
    rd_en = re; rd_spec = 4'(rsp);
    #4;
    // expectations from the state before the edge
    exp_unf = 0; exp_ovf = 0; exp_d = 0; pop_same = 0;
    rs = m_slot[rsp]; ws = m_slot[wsp];
    if (re) begin
      if (m_mapped[rsp]) begin
        case (kind(rs))
          2:       exp_d = (m_cnt[rs] == 0) ? 0 : m_mem[rs][m_cnt[rs]-1];
          3:       exp_d = m_mem[rs][m_rp[rs]];
          default: exp_d = (m_cnt[rs] == 0) ? 0 : m_mem[rs][m_rp[rs]];
        endcase
        exp_unf = (kind(rs) != 3) && (m_cnt[rs] == 0);
      end else begin
        exp_d = m_rf[rsp];
      end
      check(tag, rd_data, exp_d);
    end
    if (we && m_mapped[wsp] && (kind(ws) == 1 || kind(ws) == 2)) begin
      pop_same = re && m_mapped[rsp] && rs == ws && m_cnt[ws] != 0;
      exp_ovf = (m_cnt[ws] == m_dep[ws]) && !pop_same;
    end
    check("R10 underflow flag", {31'd0, unf}, {31'd0, exp_unf});
    check("R11 overflow flag",  {31'd0, ovf}, {31'd0, exp_ovf});
    // edge effects: read, then write, then command
    if (re && m_mapped[rsp]) begin
      case (kind(rs))
        1, 2: if (m_cnt[rs] > 0) begin
          if (kind(rs) == 1) m_rp[rs] = (m_rp[rs] + 1) % m_dep[rs];
          m_cnt[rs]--;
        end
        3: m_rp[rs] = (m_rp[rs] + 1) % m_dep[rs];
        default: ;
      endcase
    end
    if (we) begin
      if (!m_mapped[wsp]) m_rf[wsp] = wd;
      else begin
        case (kind(ws))
          0: begin
            m_mem[ws][m_wp[ws]] = wd;
            m_wp[ws] = (m_wp[ws] + 1) % m_dep[ws];
            if (m_cnt[ws] == m_dep[ws]) m_rp[ws] = (m_rp[ws] + 1) % m_dep[ws];
            else m_cnt[ws]++;
          end
          1: if (m_cnt[ws] < m_dep[ws]) begin
            m_mem[ws][m_wp[ws]] = wd;
            m_wp[ws] = (m_wp[ws] + 1) % m_dep[ws];
            m_cnt[ws]++;
          end
          2: if (m_cnt[ws] < m_dep[ws]) begin
            m_mem[ws][m_cnt[ws]] = wd;
            m_cnt[ws]++;
          end
          default: begin
            m_mem[ws][m_wp[ws]] = wd;
            m_wp[ws] = (m_wp[ws] + 1) % m_dep[ws];
          end
        endcase
      end
    end
    if (me) begin
      if (mu) begin
        if (m_mapped[msp]) begin
          int s = m_slot[msp];
          m_cnt[s] = 0; m_rp[s] = 0; m_wp[s] = 0;
          m_mapped[msp] = 0;
        end
      end else if (msl < 5) begin
        m_mapped[msp] = 1; m_slot[msp] = msl; m_dep[msl] = mdf + 1;
        m_cnt[msl] = 0; m_rp[msl] = 0; m_wp[msl] = 0;
      end
    end
  endtask

  task automatic do_map(input string t, input int sp, input int sl, input int df);
    step(t, 1, 0, sp, df, sl, 0, 0, 0, 0, 0);
  endtask
  task automatic do_unmap(input string t, input int sp);
    step(t, 1, 1, sp, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_wr(input string t, input int sp, input logic [31:0] d);
    step(t, 0, 0, 0, 0, 0, 1, sp, d, 0, 0);
  endtask
  task automatic do_rd(input string t, input int sp);
    step(t, 0, 0, 0, 0, 0, 0, 0, 0, 1, sp);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state and plain register access
    for (int i = 0; i < 16; i++) do_rd("R1 reset read", i);
    do_wr("R1 write", 1, 32'h11);
    do_rd("R1 readback", 1);
    // R2: same-cycle write uses old routing, next cycle redirected
    step("R2 map with write", 1, 0, 3, 2, 3, 1, 3, 32'hAA, 0, 0);
    do_rd("R2 empty after map", 3);
    // R6 stack, depth 3
    do_wr("R6 push", 3, 10); do_wr("R6 push", 3, 20); do_wr("R6 push", 3, 30);
    do_wr("R11 push full", 3, 40);
    do_rd("R6 pop", 3); do_rd("R6 pop", 3); do_rd("R6 pop", 3);
    do_rd("R10 pop empty", 3);
    do_unmap("R4 unmap", 3);
    do_rd("R3 register kept", 3);
    // R7 consuming queue, depth 2
    do_map("R7 map", 5, 2, 1);
    do_wr("R7 enq", 5, 1); do_wr("R7 enq", 5, 2);
    do_wr("R11 enq full", 5, 3);
    step("R12 read and write", 0, 0, 0, 0, 0, 1, 5, 4, 1, 5);
    do_rd("R7 deq", 5); do_rd("R7 deq", 5); do_rd("R10 deq empty", 5);
    // R8 keeping queue, depth 3
    do_map("R8 map", 6, 0, 2);
    do_wr("R8 w", 6, 32'hA); do_wr("R8 w", 6, 32'hB);
    do_wr("R8 w", 6, 32'hC); do_wr("R8 w", 6, 32'hD);
    do_rd("R8 oldest", 6); do_rd("R8 oldest again", 6);
    // R9 circular, depth 2
    do_map("R9 map", 7, 4, 1);
    do_wr("R9 w", 7, 32'h100); do_wr("R9 w", 7, 32'h200); do_wr("R9 w", 7, 32'h300);
    do_rd("R9 r", 7); do_rd("R9 r", 7); do_rd("R9 wrap", 7);
    do_map("R9 remap", 7, 4, 1);
    do_rd("R9 data kept", 7);
    // R4 unmap and remap
    do_unmap("R4 unmap", 6);
    do_rd("R4 back to register", 6);
    do_map("R4 remap", 6, 0, 2);
    do_rd("R4 remap empty", 6);
    do_unmap("R4 unmap unmapped", 9);
    do_wr("R4 unmapped write", 9, 32'h99);
    do_rd("R4 unmapped read", 9);
    // R5 bad slot index
    do_map("R5 bad slot", 8, 6, 3);
    do_wr("R5 write", 8, 32'h88);
    do_rd("R5 stays register", 8);
    // R12 random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      bit me = ($urandom_range(0, 19) == 0);
      step("R12 random", me, me && ($urandom_range(0, 3) == 0),
           $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 5),
           $urandom_range(0, 1) == 1, $urandom_range(0, 7), $urandom(),
           $urandom_range(0, 1) == 1, $urandom_range(0, 7));
    end
    @(negedge clk);
    map_en = 0; wr_en = 0; rd_en = 0;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule